// File: doc/BRIEF.md
# Hook-Switch Supervisor with Automatic Ring Trip

This block watches a raw loop-current indication from the line front end. It turns that indication into a clean hook state, which it presents on an active-low switch-hook output and on an LED drive output. Outside ringing, a short qualification window filters contact bounce. The window is short enough that the breaks and makes of rotary dialling still reach the hook output.

While the controller asks for ringing, the block energizes the ring relay drive and switches to a much longer qualification window. This stops the AC ringing current from posing as an off-hook. For a few milliseconds after every relay switch, the detect input is disregarded so that the switching transient cannot count. When the subscriber answers, the block drops the relay drive by itself and emits a one-clock trip event. The relay then stays off until the controller withdraws the ring request and issues it again.

All timing counts in units of a one-millisecond tick supplied from outside. The raw detect is synchronized inside the block before it is used.

Top module: `hook_ring_supervisor`

## Requirements
- R1: After reset, `hook_n` and `led_n` are 1 (on-hook), `ring_relay` is 0 and `trip_pulse` is 0.
- R2: `hook_n` is 0 while the qualified state is off-hook and 1 while it is on-hook. `led_n` always carries the same value as `hook_n`.
- R3: Outside ringing, a change of `loop_det` (1 = loop current) is accepted only after it has held for IDLE_QUAL_MS consecutive ticks (default 10), in either direction. A shorter excursion leaves `hook_n` unchanged. With the defaults, a held change reaches `hook_n` within 20 ms.
- R4: Dial-pulse breaks and makes that last at least IDLE_QUAL_MS ticks each are reproduced on `hook_n`.
- R5: From the on-hook state, `ring_relay` rises on the clock edge that samples `ring_req` high. It falls on the edge that samples `ring_req` low, with no trip event.
- R6: While `ring_relay` is 1, off-hook is accepted only after `loop_det` has stayed high for RING_QUAL_MS consecutive ticks (default 50). Any low sample restarts the count. An accepted off-hook drives `hook_n` to 0 and turns `ring_relay` off one clock later, well inside 100 ms.
- R7: For BLANK_MS ticks (default 4) after every edge of `ring_relay`, `loop_det` is ignored and no qualification progress is made.
- R8: Each ring trip raises `trip_pulse` for exactly one clock, in the cycle after `hook_n` falls.
- R9: After a trip, `ring_relay` stays 0 while `ring_req` stays high, even if the line returns on-hook. It rises again only after `ring_req` has been sampled low and then high.
- R10: A ring request made while the line is already off-hook does not energize the relay and produces no trip event.
- R11: If `ring_req` is sampled low in the same cycle in which an off-hook accepted during ringing is acted on, the trip still wins: `trip_pulse` fires once and the relay goes off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| loop_det | input | 1 | Raw loop-current detect, 1 = current flowing (asynchronous) |
| ring_req | input | 1 | Ringing request from the controller |
| ms_tick | input | 1 | One-clock pulse every millisecond |
| hook_n | output | 1 | Qualified hook state, 0 = off-hook |
| led_n | output | 1 | LED drive, 0 = lit (off-hook) |
| ring_relay | output | 1 | Ring relay drive, 1 = energized |
| trip_pulse | output | 1 | One-clock ring-trip event |

## Verification
The delicate coincidence is a qualified answer during ringing that is acted on in the very cycle the controller withdraws its ring request. Both events decide the next state of the relay controller. The bench polls `hook_n` at every falling clock edge while ringing with the loop closed. At the first low sample it drops `ring_req` at once, so the withdrawal lands on the same edge as the trip decision. The outcome is judged at the ports: exactly one `trip_pulse` must appear one clock later, and the relay must be off. A second overlap, a relay edge with detect already high, is judged by the trip arriving only after the blanking window plus the full ringing count.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

    typedef enum logic [1:0] {
        RING_IDLE    = 2'd0,
        RING_ACTIVE  = 2'd1,
        RING_TRIPPED = 2'd2
    } ring_state_e;

    typedef struct packed {
        logic off_hook;   // qualified hook state, 1 = off-hook
        logic went_off;   // one-clock mark of an on-to-off transition
    } hook_evt_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hrs_hook_qual.sv
module hrs_hook_qual
    import hrs_pkg::*;
#(
    parameter int unsigned IDLE_QUAL_MS = 10,
    parameter int unsigned RING_QUAL_MS = 50,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      loop_det,
    input  logic      ms_tick,
    input  logic      ring_mode,
    input  logic      blank,
    output hook_evt_t evt
);

    localparam int unsigned MAXQ = max_u(IDLE_QUAL_MS, RING_QUAL_MS);
    localparam int unsigned CW   = $clog2(MAXQ + 2);

    logic           det_s;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  limit;
    logic           off_q;
    logic           went_q;

    // metastability guard on the asynchronous detect
    generate
        if (SYNC_STAGES < 2) begin : g_sync1
            logic s1;
            always_ff @(posedge clk) begin
                if (rst) s1 <= 1'b0;
                else     s1 <= loop_det;
            end
            assign det_s = s1;
        end else begin : g_syncn
            logic [SYNC_STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[SYNC_STAGES-2:0], loop_det};
            end
            assign det_s = sh[SYNC_STAGES-1];
        end
    endgenerate

    assign limit = ring_mode ? CW'(RING_QUAL_MS) : CW'(IDLE_QUAL_MS);

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q  <= 1'b0;
            went_q <= 1'b0;
            cnt    <= '0;
        end else begin
            went_q <= 1'b0;
            if (det_s == off_q || blank) begin
                cnt <= '0;
            end else if (ms_tick) begin
                if (cnt >= limit - CW'(1)) begin
                    off_q  <= det_s;
                    went_q <= det_s;
                    cnt    <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    assign evt.off_hook = off_q;
    assign evt.went_off = went_q;

    // R3: the state only moves on a tick edge
    p_tick_only_r3: assert property (@(posedge clk) disable iff (rst)
        !ms_tick |=> $stable(off_q));

    // R7: no state change while blanking
    p_blank_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        blank |=> $stable(off_q));

endmodule

// File: rtl/hrs_ring_ctl.sv
module hrs_ring_ctl
    import hrs_pkg::*;
#(
    parameter int unsigned BLANK_MS = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ring_req,
    input  logic      ms_tick,
    input  hook_evt_t evt,
    output logic      relay_on,
    output logic      blank,
    output logic      trip_pulse
);

    localparam int unsigned BW = $clog2(BLANK_MS + 2);

    ring_state_e   st, st_n;
    logic          trip_n;
    logic [BW-1:0] bcnt;

    always_comb begin
        st_n   = st;
        trip_n = 1'b0;
        unique case (st)
            RING_IDLE: begin
                if (ring_req) st_n = evt.off_hook ? RING_TRIPPED : RING_ACTIVE;
            end
            RING_ACTIVE: begin
                if (evt.went_off) begin
                    st_n   = RING_TRIPPED;
                    trip_n = 1'b1;
                end else if (!ring_req) begin
                    st_n = RING_IDLE;
                end
            end
            RING_TRIPPED: begin
                if (!ring_req) st_n = RING_IDLE;
            end
            default: st_n = RING_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= RING_IDLE;
            trip_pulse <= 1'b0;
            bcnt       <= '0;
        end else begin
            st         <= st_n;
            trip_pulse <= trip_n;
            if ((st_n == RING_ACTIVE) != (st == RING_ACTIVE))
                bcnt <= BW'(BLANK_MS);
            else if (ms_tick && bcnt != '0)
                bcnt <= bcnt - BW'(1);
        end
    end

    assign relay_on = (st == RING_ACTIVE);
    assign blank    = (bcnt != '0);

    // R8: trip event lasts one clock
    p_trip_one_clk_r8: assert property (@(posedge clk) disable iff (rst)
        trip_pulse |=> !trip_pulse);

    // R6: a trip leaves the relay off
    p_trip_relay_off_r6: assert property (@(posedge clk) disable iff (rst)
        trip_pulse |-> !relay_on);

    // R5: no relay drive without a request
    p_relay_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
        !ring_req |=> !relay_on);

    // R9: tripped with request still high keeps the relay off
    p_trip_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (st == RING_TRIPPED && ring_req) |=> !relay_on);

endmodule

// File: rtl/hook_ring_supervisor.sv
module hook_ring_supervisor
    import hrs_pkg::*;
#(
    parameter int unsigned IDLE_QUAL_MS = 10,
    parameter int unsigned RING_QUAL_MS = 50,
    parameter int unsigned BLANK_MS     = 4,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic loop_det,
    input  logic ring_req,
    input  logic ms_tick,
    output logic hook_n,
    output logic led_n,
    output logic ring_relay,
    output logic trip_pulse
);

    hook_evt_t evt;
    logic      relay_on;
    logic      blank;

    hrs_hook_qual #(
        .IDLE_QUAL_MS (IDLE_QUAL_MS),
        .RING_QUAL_MS (RING_QUAL_MS),
        .SYNC_STAGES  (SYNC_STAGES)
    ) u_qual (
        .clk       (clk),
        .rst       (rst),
        .loop_det  (loop_det),
        .ms_tick   (ms_tick),
        .ring_mode (relay_on),
        .blank     (blank),
        .evt       (evt)
    );

    hrs_ring_ctl #(
        .BLANK_MS (BLANK_MS)
    ) u_ring (
        .clk        (clk),
        .rst        (rst),
        .ring_req   (ring_req),
        .ms_tick    (ms_tick),
        .evt        (evt),
        .relay_on   (relay_on),
        .blank      (blank),
        .trip_pulse (trip_pulse)
    );

    assign hook_n     = ~evt.off_hook;
    assign led_n      = hook_n;
    assign ring_relay = relay_on;

    // R8: a trip event follows a fall of the hook output by one clock
    p_trip_after_hook_r8: assert property (@(posedge clk) disable iff (rst)
        trip_pulse |-> (!hook_n && $past(evt.went_off)));

endmodule

// File: tb/hook_ring_supervisor_tb_top.sv
`timescale 1ns/1ps
module hook_ring_supervisor_tb_top;

    localparam int TICKP = 20;   // clocks per ms tick in the bench

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic loop_det = 1'b0;
    logic ring_req = 1'b0;
    logic ms_tick = 1'b0;
    logic hook_n, led_n, ring_relay, trip_pulse;

    int n_checks = 0;
    int n_fail = 0;
    int trips = 0;
    bit done = 0;
    bit prev_pulse = 0;

    typedef struct {
        string req;
        logic  hook;
        logic  relay;
        int    trips;
        int    pulse;   // -1 = not checked
    } exp_t;

    exp_t sb[$];
    event chk_ev;

    hook_ring_supervisor dut_i (
        .clk        (clk),
        .rst        (rst),
        .loop_det   (loop_det),
        .ring_req   (ring_req),
        .ms_tick    (ms_tick),
        .hook_n     (hook_n),
        .led_n      (led_n),
        .ring_relay (ring_relay),
        .trip_pulse (trip_pulse)
    );

    always #10 clk = ~clk;   // 50 MHz

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            ms_tick = (div == TICKP - 1);
            div = (div == TICKP - 1) ? 0 : div + 1;
        end
    end

    // trip event counter and width check (R8)
    always @(negedge clk) begin
        if (!rst) begin
            if (trip_pulse) trips++;
            if (trip_pulse && prev_pulse) begin
                n_checks++; n_fail++;
                $display("FAIL R8 trip_pulse wider than one clock: got 1 expected 0");
            end
            prev_pulse = trip_pulse;
        end
    end

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (hook_n !== e.hook || led_n !== e.hook || ring_relay !== e.relay ||
                    trips != e.trips || (e.pulse >= 0 && trip_pulse !== e.pulse[0])) begin
                    n_fail++;
                    $display("FAIL %s: hook_n=%b led_n=%b relay=%b trips=%0d pulse=%b expected hook=%b relay=%b trips=%0d pulse=%0d",
                             e.req, hook_n, led_n, ring_relay, trips, trip_pulse,
                             e.hook, e.relay, e.trips, e.pulse);
                end
            end
        end
    end

    task automatic expect_st(input string req, input logic h, input logic r,
                             input int t, input int p = -1);
        exp_t e;
        e.req = req; e.hook = h; e.relay = r; e.trips = t; e.pulse = p;
        sb.push_back(e);
        ->chk_ev;
        @(negedge clk);
    endtask

    task automatic wait_ms(input int n);
        repeat (n * TICKP) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        expect_st("R1 reset state", 1'b1, 1'b0, 0, 0);

        // R3: short excursion rejected
        loop_det = 1'b1; wait_ms(5);
        loop_det = 1'b0; wait_ms(15);
        expect_st("R3 short glitch ignored", 1'b1, 1'b0, 0);

        // R3: held change accepted, not early
        loop_det = 1'b1; wait_ms(8);
        expect_st("R3 not yet qualified", 1'b1, 1'b0, 0);
        wait_ms(4);
        expect_st("R2 off-hook drives hook_n low", 1'b0, 1'b0, 0);
        loop_det = 1'b0; wait_ms(12);
        expect_st("R3 on-hook direction", 1'b1, 1'b0, 0);

        // R4: dial pulses
        loop_det = 1'b1; wait_ms(15);
        for (int i = 0; i < 3; i++) begin
            loop_det = 1'b0; wait_ms(30);
            expect_st("R4 dial break seen", 1'b1, 1'b0, 0);
            wait_ms(30);
            loop_det = 1'b1; wait_ms(25);
            expect_st("R4 dial make seen", 1'b0, 1'b0, 0);
            wait_ms(15);
        end

        // R10: ring request while off-hook
        ring_req = 1'b1; repeat (3) @(negedge clk);
        expect_st("R10 no relay when off-hook", 1'b0, 1'b0, 0);
        wait_ms(10);
        expect_st("R10 still no relay, no trip", 1'b0, 1'b0, 0);
        ring_req = 1'b0;
        loop_det = 1'b0; wait_ms(15);
        expect_st("R3 back on-hook", 1'b1, 1'b0, 0);

        // R5: relay follows request
        ring_req = 1'b1; repeat (2) @(negedge clk);
        expect_st("R5 relay on", 1'b1, 1'b1, 0);
        wait_ms(10);
        for (int i = 0; i < 3; i++) begin
            loop_det = 1'b1; wait_ms(30);
            loop_det = 1'b0; wait_ms(10);
        end
        expect_st("R6 ringing current filtered", 1'b1, 1'b1, 0);
        ring_req = 1'b0; repeat (2) @(negedge clk);
        expect_st("R5 relay off on withdrawal", 1'b1, 1'b0, 0);
        wait_ms(10);

        // R7 + R6: answer together with relay edge
        loop_det = 1'b1; ring_req = 1'b1;
        repeat (52 * TICKP + TICKP / 2) @(negedge clk);
        expect_st("R7 blanking delays trip", 1'b1, 1'b1, 0);
        wait_ms(4);
        expect_st("R6 ring trip", 1'b0, 1'b0, 1);

        // R9: sticky off
        wait_ms(20);
        expect_st("R9 relay stays off", 1'b0, 1'b0, 1);
        loop_det = 1'b0; wait_ms(20);
        expect_st("R9 off after on-hook", 1'b1, 1'b0, 1);
        ring_req = 1'b0; repeat (2) @(negedge clk);
        ring_req = 1'b1; repeat (2) @(negedge clk);
        expect_st("R9 re-armed", 1'b1, 1'b1, 1);

        // R11: withdrawal coincides with trip decision
        wait_ms(10);
        loop_det = 1'b1;
        for (int i = 0; i < 100 * TICKP; i++) begin
            if (hook_n == 1'b0) break;
            @(negedge clk);
        end
        ring_req = 1'b0;
        @(negedge clk);
        expect_st("R8 pulse one clock after hook_n fall", 1'b0, 1'b0, 2, 1);
        expect_st("R11 trip wins over withdrawal", 1'b0, 1'b0, 2, 0);

        loop_det = 1'b0; wait_ms(15);
        expect_st("R2 final on-hook", 1'b1, 1'b0, 2);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule